// File: doc/BRIEF.md
# Indexed Event Counter Bank with Limit Interrupt

This block holds a parameterised set of hardware event counters behind one small register window. Software picks a counter by writing a select register. It then loads that counter's start value in two 32-bit halves and programs a per-counter limit. While a counter runs, it adds one on every clock cycle in which its event input is high. When an increment makes the count equal to the limit, a sticky flag is set and, if that counter's interrupt is enabled, the interrupt output rises.

The counter does not stop or wrap at the limit. It keeps counting, so events that arrive before the handler runs are still recorded. A profiling driver can therefore start a counter at "limit minus period", take the interrupt, and read the overshoot from the live snapshot. A constant build register reports how many counters there are and the size field that sets their width (32 + 16 × size bits).

Register window (4-bit word address):

| Address | Name | Access |
|---|---|---|
| 0 | CTRL | bit 0 is the global run bit; bit 16+i enables the interrupt of counter i |
| 1 | SEL | selects a counter |
| 2 | CNT_LO | staged low word; reads back the staged value |
| 3 | CNT_HI | a write loads the selected counter |
| 4 | LIM_LO | limit of the selected counter, low word |
| 5 | LIM_HI | limit of the selected counter, high word |
| 6 | SNAP_LO | live count of the selected counter, low word (read only) |
| 7 | SNAP_HI | live count of the selected counter, high word (read only) |
| 8 | RUN | bit i enables counter i |
| 9 | FLAGS | bit i is the flag of counter i; write 1 to clear |
| 10 | BUILD | read only |

Top module: `evt_cnt_bank`

## Requirements
- R1: After reset every count is 0, every limit is all ones across the counter width, all flags are 0, CTRL and RUN read 0, and `irq` is 0.
- R2: The value in SEL (address 1) decides which counter the CNT_HI load, the LIM_LO/LIM_HI accesses and the SNAP_LO/SNAP_HI reads apply to. No other counter is touched.
- R3: A write to CNT_LO (address 2) only stages the low word and leaves the counter unchanged. A write to CNT_HI (address 3) loads the selected counter with {high word, staged low word} at the next edge. In that cycle the load takes priority over an increment.
- R4: A counter adds exactly one on each clock edge at which its event input is high, CTRL bit 0 is 1 and its RUN bit (address 8, bit i) is 1. Otherwise it holds its value.
- R5: Writing CTRL with its low half zero stops all counting. CTRL bits 16+i hold the interrupt enable of counter i.
- R6: An increment that makes a count equal to its limit sets that counter's flag at the same edge, including when the increment carries from the low word into the high word.
- R7: Reaching the limit does not stop the counter, and a set flag stays set while counting goes on.
- R8: Writing 1 to bit i of FLAGS (address 9) clears flag i, and writing 0 leaves it unchanged. `irq` is high exactly when some flag i and CTRL bit 16+i are both 1.
- R9: SNAP_LO/SNAP_HI (addresses 6 and 7) return the live count of the selected counter, and reading them does not change it.
- R10: Bits at or above the counter width read as zero, high-word bits beyond the width are dropped on a write, and a counter at its maximum value wraps to 0 on the next increment.
- R11: BUILD (address 10) reads the number of counters in bits [7:0] and the size field in bits [9:8]. With the defaults (4 counters, size 1, 48-bit counters) it reads 0x104.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_in | input | N_CNT | One event input per counter |
| irq | output | 1 | OR of the enabled counter flags |

## Verification
The count function is driven with event bursts of known length on all inputs at once while only one counter is enabled. This separates correct per-counter gating from crosstalk between counters or a missing global stop. The limit compare is tried with a start value just below a low-word carry, so a compare that misses the high word or fires one count early shows up as a flag at the wrong snapshot. A counter at its all-ones value with a zero limit covers wrap and masked interrupts together. A load written in the same cycle as an event shows whether the load wins over the increment.

// File: rtl/evc_pkg.sv
// Package: register word addresses of the event counter window and a width helper.
// Assumes a 4-bit word address; unlisted addresses read zero and ignore writes.
package evc_pkg;
    localparam logic [3:0] A_CTRL    = 4'd0;
    localparam logic [3:0] A_SEL     = 4'd1;
    localparam logic [3:0] A_CNT_LO  = 4'd2;
    localparam logic [3:0] A_CNT_HI  = 4'd3;
    localparam logic [3:0] A_LIM_LO  = 4'd4;
    localparam logic [3:0] A_LIM_HI  = 4'd5;
    localparam logic [3:0] A_SNAP_LO = 4'd6;
    localparam logic [3:0] A_SNAP_HI = 4'd7;
    localparam logic [3:0] A_RUN     = 4'd8;
    localparam logic [3:0] A_FLAGS   = 4'd9;
    localparam logic [3:0] A_BUILD   = 4'd10;

    // Counter width implied by the size field.
    function automatic int cnt_width(input int size_sel);
        return 32 + 16 * size_sel;
    endfunction
endpackage

// File: rtl/evc_slot.sv
// Module: one counter slot holding a count, a limit and a sticky limit flag.
// Assumes the caller gates inc with all enables; a load wins over an increment,
// and the flag is only set by an increment landing exactly on the limit.
module evc_slot #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         lim_lo_wr,
    input  logic         lim_hi_wr,
    input  logic [31:0]  wdata,
    input  logic         clr,
    output logic [W-1:0] count,
    output logic [W-1:0] limit,
    output logic         flag
);
    logic [W-1:0] nxt;
    logic [31:0]  lim_lo;
    logic         hit_now;

    assign nxt     = count + W'(1);
    assign hit_now = inc && !load && (nxt == limit);

    // Count register: reset, load from the window, or step on an event.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= load_val;
        else if (inc)  count <= nxt;
    end

    // Low limit word written from the window.
    always_ff @(posedge clk) begin
        if (!rst_n)         lim_lo <= '1;
        else if (lim_lo_wr) lim_lo <= wdata;
    end

    generate
        if (W > 32) begin : g_hi
            logic [W-33:0] lim_hi;
            // High limit word, only as wide as the counter needs.
            always_ff @(posedge clk) begin
                if (!rst_n)         lim_hi <= '1;
                else if (lim_hi_wr) lim_hi <= wdata[W-33:0];
            end
            assign limit = {lim_hi, lim_lo};
        end else begin : g_lo
            assign limit = lim_lo;
        end
    endgenerate

    // Sticky flag: set on reaching the limit (set wins), cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (hit_now) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end
endmodule

// File: rtl/evc_readback.sv
// Module: read multiplexer of the counter window; selects per-counter state by SEL.
// Assumes SEL values at or above N_CNT select nothing and read zero.
module evc_readback
    import evc_pkg::*;
#(
    parameter int N_CNT    = 4,
    parameter int W        = 48,
    parameter int IW       = 2,
    parameter int SIZE_SEL = 1
) (
    input  logic [3:0]              addr,
    input  logic [IW-1:0]           sel,
    input  logic [N_CNT-1:0][W-1:0] counts,
    input  logic [N_CNT-1:0][W-1:0] limits,
    input  logic [N_CNT-1:0]        flags,
    input  logic [N_CNT-1:0]        run_mask,
    input  logic [N_CNT-1:0]        ien,
    input  logic                    ctrl_run,
    input  logic [31:0]             lo_stage,
    output logic [31:0]             rdata
);
    logic [63:0] cur_cnt;
    logic [63:0] cur_lim;

    // Pick the selected counter's count and limit, zero-extended to 64 bits.
    always_comb begin
        cur_cnt = '0;
        cur_lim = '0;
        for (int i = 0; i < N_CNT; i++) begin
            if (sel == IW'(i)) begin
                cur_cnt = 64'(counts[i]);
                cur_lim = 64'(limits[i]);
            end
        end
    end

    // Address decode of the read data.
    always_comb begin
        case (addr)
            A_CTRL:    rdata = {16'(ien), 15'd0, ctrl_run};
            A_SEL:     rdata = 32'(sel);
            A_CNT_LO:  rdata = lo_stage;
            A_LIM_LO:  rdata = cur_lim[31:0];
            A_LIM_HI:  rdata = cur_lim[63:32];
            A_SNAP_LO: rdata = cur_cnt[31:0];
            A_SNAP_HI: rdata = cur_cnt[63:32];
            A_RUN:     rdata = 32'(run_mask);
            A_FLAGS:   rdata = 32'(flags);
            A_BUILD:   rdata = {22'd0, 2'(SIZE_SEL), 8'(N_CNT)};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/evt_cnt_bank.sv
// Module: top of the event counter bank; decodes window writes, holds control,
// select and staging registers, and instantiates one slot per counter.
// Assumes N_CNT <= 16 (interrupt enables live in CTRL[31:16]) and SIZE_SEL in 0..2.
module evt_cnt_bank
    import evc_pkg::*;
#(
    parameter int N_CNT    = 4,
    parameter int SIZE_SEL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [N_CNT-1:0] evt_in,
    output logic             irq
);
    localparam int W  = cnt_width(SIZE_SEL);
    localparam int IW = (N_CNT > 1) ? $clog2(N_CNT) : 1;

    logic                    ctrl_run_q;
    logic [N_CNT-1:0]        ien_q;
    logic [N_CNT-1:0]        run_mask_q;
    logic [IW-1:0]           sel_q;
    logic [31:0]             lo_stage_q;
    logic [N_CNT-1:0][W-1:0] cnt_all;
    logic [N_CNT-1:0][W-1:0] lim_all;
    logic [N_CNT-1:0]        flag_vec;
    logic [N_CNT-1:0]        inc_vec;
    logic [N_CNT-1:0]        load_vec;
    logic [N_CNT-1:0]        clr_vec;
    logic [63:0]             full_load;
    logic [W-1:0]            load_val;
    logic                    wr_ctrl, wr_sel, wr_lo, wr_hi, wr_llo, wr_lhi, wr_run, wr_flg;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_sel  = bus_wr && (bus_addr == A_SEL);
    assign wr_lo   = bus_wr && (bus_addr == A_CNT_LO);
    assign wr_hi   = bus_wr && (bus_addr == A_CNT_HI);
    assign wr_llo  = bus_wr && (bus_addr == A_LIM_LO);
    assign wr_lhi  = bus_wr && (bus_addr == A_LIM_HI);
    assign wr_run  = bus_wr && (bus_addr == A_RUN);
    assign wr_flg  = bus_wr && (bus_addr == A_FLAGS);

    assign full_load = {bus_wdata, lo_stage_q};
    assign load_val  = full_load[W-1:0];

    // Global control: run bit and per-counter interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_run_q <= 1'b0;
            ien_q      <= '0;
        end else if (wr_ctrl) begin
            ctrl_run_q <= bus_wdata[0];
            ien_q      <= bus_wdata[16 +: N_CNT];
        end
    end

    // Counter select register.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (wr_sel) sel_q <= bus_wdata[IW-1:0];
    end

    // Staging register for the low word of a start value.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_stage_q <= '0;
        else if (wr_lo) lo_stage_q <= bus_wdata;
    end

    // Per-counter run enables.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_mask_q <= '0;
        else if (wr_run) run_mask_q <= bus_wdata[N_CNT-1:0];
    end

    generate
        for (genvar g = 0; g < N_CNT; g++) begin : g_slot
            assign inc_vec[g]  = ctrl_run_q && run_mask_q[g] && evt_in[g];
            assign load_vec[g] = wr_hi && (sel_q == IW'(g));
            assign clr_vec[g]  = wr_flg && bus_wdata[g];

            evc_slot #(.W(W)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .inc       (inc_vec[g]),
                .load      (load_vec[g]),
                .load_val  (load_val),
                .lim_lo_wr (wr_llo && (sel_q == IW'(g))),
                .lim_hi_wr (wr_lhi && (sel_q == IW'(g))),
                .wdata     (bus_wdata),
                .clr       (clr_vec[g]),
                .count     (cnt_all[g]),
                .limit     (lim_all[g]),
                .flag      (flag_vec[g])
            );
        end
    endgenerate

    assign irq = |(flag_vec & ien_q);

    evc_readback #(
        .N_CNT(N_CNT), .W(W), .IW(IW), .SIZE_SEL(SIZE_SEL)
    ) u_rd (
        .addr     (bus_addr),
        .sel      (sel_q),
        .counts   (cnt_all),
        .limits   (lim_all),
        .flags    (flag_vec),
        .run_mask (run_mask_q),
        .ien      (ien_q),
        .ctrl_run (ctrl_run_q),
        .lo_stage (lo_stage_q),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/evc_chk.sv
// Module: assertion checker for evt_cnt_bank, attached by bind below.
// Assumes it sees the top's internal count, limit, flag and strobe vectors.
module evc_chk #(
    parameter int N_CNT = 4,
    parameter int W     = 48
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [3:0]              bus_addr,
    input logic [31:0]             bus_rdata,
    input logic                    irq,
    input logic                    ctrl_run_q,
    input logic [N_CNT-1:0]        ien_q,
    input logic [N_CNT-1:0][W-1:0] cnt_all,
    input logic [N_CNT-1:0][W-1:0] lim_all,
    input logic [N_CNT-1:0]        flag_vec,
    input logic [N_CNT-1:0]        inc_vec,
    input logic [N_CNT-1:0]        load_vec,
    input logic [N_CNT-1:0]        clr_vec
);
    generate
        for (genvar i = 0; i < N_CNT; i++) begin : g_chk
            AST_REACH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
                (inc_vec[i] && !load_vec[i] && ((cnt_all[i] + W'(1)) == lim_all[i])) |=> flag_vec[i]); // R6
            AST_COUNTS_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
                (inc_vec[i] && !load_vec[i]) |=> (cnt_all[i] == $past(cnt_all[i]) + W'(1))); // R7
            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_vec[i] && !clr_vec[i]) |=> flag_vec[i]); // R7
            AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (!ctrl_run_q && !load_vec[i]) |=> $stable(cnt_all[i])); // R5
        end
    endgenerate

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flag_vec & ien_q) != '0)); // R8
    AST_SNAP_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 4'd7) |-> ((64'(bus_rdata) >> (W - 32)) == 64'd0)); // R10
endmodule

bind evt_cnt_bank evc_chk #(.N_CNT(N_CNT), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .ctrl_run_q (ctrl_run_q),
    .ien_q      (ien_q),
    .cnt_all    (cnt_all),
    .lim_all    (lim_all),
    .flag_vec   (flag_vec),
    .inc_vec    (inc_vec),
    .load_vec   (load_vec),
    .clr_vec    (clr_vec)
);

// File: tb/tb_evt_cnt_bank.sv
// Bench: directed scenarios for evt_cnt_bank with defaults (4 counters, 48 bits).
module tb_evt_cnt_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  evt_in = '0;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    evt_cnt_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic snap(output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(4'd6, lo);
        rd(4'd7, hi);
        v = {hi, lo};
    endtask

    task automatic load(input logic [3:0] idx, input logic [63:0] v);
        wr(4'd1, 32'(idx));
        wr(4'd2, v[31:0]);
        wr(4'd3, v[63:32]);
    endtask

    task automatic burst(input logic [3:0] mask, input int k);
        @(negedge clk);
        evt_in = mask;
        repeat (k) @(posedge clk);
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        logic [63:0] v;
        rd(4'd10, d); check("R11 build", 64'(d), 64'h104);
        snap(v);      check("R1 count zero", v, 64'h0);
        rd(4'd4, d);  check("R1 limit lo", 64'(d), 64'hFFFF_FFFF);
        rd(4'd5, d);  check("R10 limit hi width", 64'(d), 64'hFFFF);
        rd(4'd9, d);  check("R1 flags", 64'(d), 64'h0);
        rd(4'd0, d);  check("R1 ctrl", 64'(d), 64'h0);
        check("R1 irq", 64'(irq), 64'h0);
    endtask

    task automatic t_split;
        logic [63:0] v;
        wr(4'd1, 32'd1);
        wr(4'd2, 32'h89AB_CDEF);
        snap(v); check("R3 staged only", v, 64'h0);
        wr(4'd3, 32'hFFFF_1234);
        snap(v); check("R3 R10 loaded", v, 64'h1234_89AB_CDEF);
        wr(4'd1, 32'd0);
        snap(v); check("R2 other untouched", v, 64'h0);
    endtask

    task automatic t_count;
        logic [63:0] v;
        load(4'd2, 64'd100);
        wr(4'd8, 32'h4);
        wr(4'd0, 32'h1);
        burst(4'hF, 7);
        wr(4'd1, 32'd2);
        snap(v); check("R4 counted", v, 64'd107);
        snap(v); check("R9 snapshot stable", v, 64'd107);
        wr(4'd1, 32'd1);
        snap(v); check("R4 disabled holds", v, 64'h1234_89AB_CDEF);
    endtask

    task automatic t_stop;
        logic [63:0] v;
        wr(4'd0, 32'h0);
        burst(4'hF, 5);
        wr(4'd1, 32'd2);
        snap(v); check("R5 stopped", v, 64'd107);
    endtask

    task automatic t_limit;
        logic [63:0] v;
        logic [31:0] d;
        load(4'd0, 64'h0_FFFF_FFFE);
        wr(4'd4, 32'h1);
        wr(4'd5, 32'h1);
        wr(4'd8, 32'h1);
        wr(4'd0, 32'h0001_0001);
        burst(4'h1, 2);
        snap(v); check("R6 before limit", v, 64'h1_0000_0000);
        rd(4'd9, d); check("R6 no early flag", 64'(d), 64'h0);
        check("R8 irq low", 64'(irq), 64'h0);
        burst(4'h1, 1);
        rd(4'd9, d); check("R6 flag at limit", 64'(d), 64'h1);
        check("R8 irq high", 64'(irq), 64'h1);
        burst(4'h1, 4);
        snap(v); check("R7 counts on", v, 64'h1_0000_0005);
        check("R7 irq sticky", 64'(irq), 64'h1);
    endtask

    task automatic t_w1c;
        logic [63:0] v;
        logic [31:0] d;
        wr(4'd9, 32'hE);
        rd(4'd9, d); check("R8 zero bit keeps", 64'(d), 64'h1);
        wr(4'd9, 32'h1);
        rd(4'd9, d); check("R8 cleared", 64'(d), 64'h0);
        check("R8 irq cleared", 64'(irq), 64'h0);
        burst(4'h1, 2);
        snap(v); check("R7 after clear", v, 64'h1_0000_0007);
        rd(4'd9, d); check("R6 no refire", 64'(d), 64'h0);
    endtask

    task automatic t_wrap_mask;
        logic [63:0] v;
        logic [31:0] d;
        load(4'd3, 64'hFFFF_FFFF_FFFF);
        wr(4'd4, 32'h0);
        wr(4'd5, 32'h0);
        wr(4'd8, 32'h8);
        wr(4'd0, 32'h0000_0001);
        burst(4'h8, 1);
        snap(v); check("R10 wrap", v, 64'h0);
        rd(4'd9, d); check("R6 flag on wrap", 64'(d), 64'h8);
        check("R8 masked irq", 64'(irq), 64'h0);
        wr(4'd0, 32'h0008_0001);
        check("R8 unmasked irq", 64'(irq), 64'h1);
        wr(4'd2, 32'd50);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = 32'd0; evt_in = 4'h8;
        @(negedge clk);
        bus_wr = 1'b0; evt_in = 4'h0;
        snap(v); check("R3 load beats increment", v, 64'd50);
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog got 0 exp 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_split();
        t_count();
        t_stop();
        t_limit();
        t_w1c();
        t_wrap_mask();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule